// File: doc/BRIEF.md
# Sampled Input Glitch Filter

This block cleans up a raw, asynchronous level arriving at a timer channel before the channel's edge logic sees it. The raw level first passes through a two-flop synchroniser. It is then sampled at a rate chosen by a 4-bit filter code. The filtered output moves to a new level only after a required number of consecutive samples have all shown that level. Any sample that matches the present output discards the partial run, so a pulse shorter than the required run never appears at the output.

The sampling rate is set in one of two ways. It can be the kernel clock itself, with one sample every cycle. Or it can be derived from a base sampling clock, which arrives as a one-cycle enable pulse (`smp_base_en`) in the kernel clock domain and is divided by 1, 2, 4, 8, 16 or 32. The same code also sets the run length, which is 1, 2, 4, 5, 6 or 8 samples.

Whenever the code changes, the rate divider and the run counter restart from zero, and the output keeps its level. This lets software retune the filter while the channel is running without causing a spurious edge.

Top module: `glitch_filter`

## Requirements
- R1: While `arst_n` is low the output `lvl_out` is 0, and it goes to 0 at once when `arst_n` falls. The internal release comes two kernel clocks after `arst_n` rises.
- R2: The raw input passes through two flip-flops. The level that the filter samples on a given edge is the value `raw_in` had two edges earlier.
- R3: Code 0 takes one sample per `smp_base_en` pulse with a run length of 1. With the enable high on every cycle, a change on `raw_in` reaches `lvl_out` two cycles after the code takes effect.
- R4: Codes 1, 2 and 3 sample on every kernel clock and ignore `smp_base_en`. Their run lengths are 2, 4 and 8, so the output follows N+1 cycles after the code takes effect.
- R5: Codes 4 and 5 divide the base pulses by 2, codes 6 and 7 by 4, and codes 8 and 9 by 8. Within each pair, the even code needs 6 samples and the odd code needs 8. With the base enable high on every cycle, the output follows N*D cycles after the code takes effect.
- R6: Codes 10, 11 and 12 divide the base pulses by 16, and codes 13, 14 and 15 divide them by 32. Within each group of three, the run lengths are 5, 6 and 8 in rising code order.
- R7: A run of consecutive differing samples shorter than N leaves `lvl_out` unchanged. A run of exactly N moves `lvl_out` to the sampled level.
- R8: A sample equal to the current output clears the run count, so two short runs separated by one agreeing sample never add up.
- R9: In the base-derived codes (0 and 4 to 15), no sample is taken and `lvl_out` holds while `smp_base_en` stays low.
- R10: On a cycle where `flt_code` differs from its value on the previous cycle, the divider and the run counter clear, no sample is taken and `lvl_out` keeps its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| arst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously inside |
| smp_base_en | input | 1 | One-cycle enable marking each base sampling clock period |
| raw_in | input | 1 | Asynchronous raw input level |
| flt_code | input | 4 | Selects the sampling rate and the run length |
| lvl_out | output | 1 | Filtered level |

## Verification
Each directed test changes `raw_in` and `flt_code` on the same falling edge and takes that rising edge as edge 0. The bench works out the due edge from the requirements: edge 2 for code 0, edge N+1 for codes 1 to 3, and edge N*D for the divided codes. It samples `lvl_out` on the falling edges just before and just after the due edge, and the output must still be old at the first and already new at the second. For glitch, interruption, missing-enable and code-change scenarios, the output is watched on every falling edge across a window longer than the longest possible filter delay.

// File: rtl/glf_pkg.sv
package glf_pkg;

  localparam int CODE_W       = 4;
  localparam int DIVL_W       = 3;
  localparam int MAX_DIV_LOG2 = 5;
  localparam int NEED_W       = 3;
  localparam int SYNC_STAGES  = 2;

  typedef struct packed {
    logic              kern;
    logic [DIVL_W-1:0] div_log2;
    logic [NEED_W-1:0] need_m1;
  } flt_cfg_t;

  function automatic flt_cfg_t decode_code(input logic [CODE_W-1:0] c);
    flt_cfg_t r;
    r.kern     = 1'b0;
    r.div_log2 = '0;
    r.need_m1  = '0;
    case (c)
      4'd1:  begin r.kern = 1'b1; r.need_m1 = 3'd1; end
      4'd2:  begin r.kern = 1'b1; r.need_m1 = 3'd3; end
      4'd3:  begin r.kern = 1'b1; r.need_m1 = 3'd7; end
      4'd4:  begin r.div_log2 = 3'd1; r.need_m1 = 3'd5; end
      4'd5:  begin r.div_log2 = 3'd1; r.need_m1 = 3'd7; end
      4'd6:  begin r.div_log2 = 3'd2; r.need_m1 = 3'd5; end
      4'd7:  begin r.div_log2 = 3'd2; r.need_m1 = 3'd7; end
      4'd8:  begin r.div_log2 = 3'd3; r.need_m1 = 3'd5; end
      4'd9:  begin r.div_log2 = 3'd3; r.need_m1 = 3'd7; end
      4'd10: begin r.div_log2 = 3'd4; r.need_m1 = 3'd4; end
      4'd11: begin r.div_log2 = 3'd4; r.need_m1 = 3'd5; end
      4'd12: begin r.div_log2 = 3'd4; r.need_m1 = 3'd7; end
      4'd13: begin r.div_log2 = 3'd5; r.need_m1 = 3'd4; end
      4'd14: begin r.div_log2 = 3'd5; r.need_m1 = 3'd5; end
      4'd15: begin r.div_log2 = 3'd5; r.need_m1 = 3'd7; end
      default: ;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/glf_sync.sv
module glf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] stg;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= 1'b0;
        else        stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= 1'b0;
        else        stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/glf_rate_gen.sv
module glf_rate_gen #(
  parameter int MAX_DIV_LOG2 = 5,
  parameter int DIVL_W       = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              base_en,
  input  logic              kern,
  input  logic [DIVL_W-1:0] div_log2,
  output logic              strobe
);

  localparam int CNT_W = MAX_DIV_LOG2;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] wrap_at;
  logic             at_wrap;

  always_comb begin
    for (int i = 0; i < CNT_W; i++) begin
      wrap_at[i] = (DIVL_W'(i) < div_log2);
    end
  end

  assign at_wrap = (cnt_q == wrap_at);

  always_comb begin
    cnt_d  = cnt_q;
    strobe = 1'b0;
    if (clr) begin
      cnt_d = '0;
    end else if (kern) begin
      strobe = 1'b1;
      cnt_d  = '0;
    end else if (base_en) begin
      if (at_wrap) begin
        strobe = 1'b1;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/glf_agree.sv
module glf_agree #(
  parameter int NEED_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              strobe,
  input  logic              samp,
  input  logic [NEED_W-1:0] need_m1,
  output logic              lvl
);

  logic [NEED_W-1:0] run_q, run_d;
  logic              lvl_q, lvl_d;

  always_comb begin
    run_d = run_q;
    lvl_d = lvl_q;
    if (clr) begin
      run_d = '0;
    end else if (strobe) begin
      if (samp == lvl_q) begin
        run_d = '0;
      end else if (run_q == need_m1) begin
        run_d = '0;
        lvl_d = samp;
      end else begin
        run_d = run_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      run_q <= run_d;
      lvl_q <= lvl_d;
    end
  end

  assign lvl = lvl_q;

endmodule

// File: rtl/glitch_filter.sv
module glitch_filter
  import glf_pkg::*;
#(
  parameter int SYNC_N = SYNC_STAGES
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              smp_base_en,
  input  logic              raw_in,
  input  logic [CODE_W-1:0] flt_code,
  output logic              lvl_out
);

  logic [1:0]        rst_pipe;
  logic              rst_int_n;
  logic [CODE_W-1:0] code_q;
  logic              code_chg;
  flt_cfg_t          cfg;
  logic              samp_lvl;
  logic              strobe;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rst_pipe <= 2'b00;
    else         rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) code_q <= '0;
    else            code_q <= flt_code;
  end

  assign code_chg = (flt_code != code_q);
  assign cfg      = decode_code(flt_code);

  glf_sync #(.STAGES(SYNC_N)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     (raw_in),
    .q     (samp_lvl)
  );

  glf_rate_gen #(.MAX_DIV_LOG2(MAX_DIV_LOG2), .DIVL_W(DIVL_W)) u_rate (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .clr      (code_chg),
    .base_en  (smp_base_en),
    .kern     (cfg.kern),
    .div_log2 (cfg.div_log2),
    .strobe   (strobe)
  );

  glf_agree #(.NEED_W(NEED_W)) u_agree (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .clr     (code_chg),
    .strobe  (strobe),
    .samp    (samp_lvl),
    .need_m1 (cfg.need_m1),
    .lvl     (lvl_out)
  );

endmodule

// File: rtl/glitch_filter_chk.sv
module glitch_filter_chk (
  input logic       clk,
  input logic       arst_n,
  input logic       smp_base_en,
  input logic       raw_in,
  input logic [3:0] flt_code,
  input logic       lvl_out,
  input logic       samp_lvl
);

  logic kern_code;
  assign kern_code = (flt_code == 4'd1) || (flt_code == 4'd2) || (flt_code == 4'd3);

  // R1
  p_reset_low_r1: assert property (@(posedge clk) !arst_n |-> !lvl_out);

  // R2
  p_sync_depth_r2: assert property (@(posedge clk) disable iff (!arst_n)
    $changed(samp_lvl) |-> (samp_lvl == $past(raw_in, 2)));

  // R7
  p_move_to_sample_r7: assert property (@(posedge clk) disable iff (!arst_n)
    $changed(lvl_out) |-> (lvl_out == $past(samp_lvl)));

  // R9
  p_hold_no_base_r9: assert property (@(posedge clk) disable iff (!arst_n)
    (!smp_base_en && !kern_code && $stable(flt_code)) |=> $stable(lvl_out));

  // R10
  p_code_change_hold_r10: assert property (@(posedge clk) disable iff (!arst_n)
    $changed(flt_code) |=> $stable(lvl_out));

endmodule

bind glitch_filter glitch_filter_chk u_chk (
  .clk         (clk),
  .arst_n      (arst_n),
  .smp_base_en (smp_base_en),
  .raw_in      (raw_in),
  .flt_code    (flt_code),
  .lvl_out     (lvl_out),
  .samp_lvl    (samp_lvl)
);

// File: tb/sim_glitch_filter.sv
module sim_glitch_filter;

  logic       clk;
  logic       arst_n;
  logic       smp_base_en;
  logic       raw_in;
  logic [3:0] flt_code;
  logic       lvl_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  glitch_filter u0 (
    .clk         (clk),
    .arst_n      (arst_n),
    .smp_base_en (smp_base_en),
    .raw_in      (raw_in),
    .flt_code    (flt_code),
    .lvl_out     (lvl_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int div_of(input int c);
    if (c <= 3)  return 1;
    if (c <= 5)  return 2;
    if (c <= 7)  return 4;
    if (c <= 9)  return 8;
    if (c <= 12) return 16;
    return 32;
  endfunction

  function automatic int need_of(input int c);
    case (c)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 8;
      4, 6, 8, 11, 14: return 6;
      10, 13: return 5;
      default: return 8;
    endcase
  endfunction

  function automatic string tag_of(input int c);
    if (c == 0) return "R3";
    if (c <= 3) return "R4";
    if (c <= 9) return "R5";
    return "R6";
  endfunction

  task automatic chk(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: lvl_out=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic settle(input int c, input logic lvl);
    @(negedge clk);
    flt_code    = 4'(c);
    raw_in      = lvl;
    smp_base_en = 1'b1;
    repeat (300) @(negedge clk);
  endtask

  task automatic t_reset();
    arst_n      = 1'b1;
    smp_base_en = 1'b1;
    raw_in      = 1'b1;
    flt_code    = 4'd1;
    #1 arst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(lvl_out, 1'b0, "R1 in reset");
    arst_n = 1'b1;
    @(negedge clk);
    chk(lvl_out, 1'b0, "R1 just after release");
    settle(1, 1'b1);
    chk(lvl_out, 1'b1, "R1 running after release");
    #1 arst_n = 1'b0;
    #0.5;
    chk(lvl_out, 1'b0, "R1 async clear");
    @(negedge clk);
    arst_n = 1'b1;
  endtask

  task automatic t_latency(input int c, input logic lvl);
    int k;
    int d;
    d = div_of(c);
    if (c <= 3) k = 2 + need_of(c) - 1;
    else if (d == 1) k = 2;
    else k = need_of(c) * d;
    settle((c == 1) ? 2 : 1, ~lvl);
    @(negedge clk);
    flt_code = 4'(c);
    raw_in   = lvl;
    repeat (k) @(negedge clk);
    chk(lvl_out, ~lvl, {tag_of(c), " before due edge"});
    @(negedge clk);
    chk(lvl_out, lvl, {tag_of(c), " at due edge"});
  endtask

  task automatic pulse_watch(input int hi, input int gap, input int hi2, output bit seen);
    seen = 0;
    @(negedge clk);
    raw_in = 1'b1;
    repeat (hi) @(negedge clk);
    raw_in = 1'b0;
    repeat (gap) @(negedge clk);
    raw_in = (hi2 > 0);
    repeat (hi2) @(negedge clk);
    raw_in = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (lvl_out) seen = 1;
    end
  endtask

  task automatic t_glitch();
    bit seen;
    settle(3, 1'b0);
    pulse_watch(7, 0, 0, seen);
    chk(seen, 1'b0, "R7 run of 7 with N=8");
    settle(3, 1'b0);
    pulse_watch(8, 0, 0, seen);
    chk(seen, 1'b1, "R7 run of 8 with N=8");
  endtask

  task automatic t_interrupt();
    bit seen;
    settle(2, 1'b0);
    pulse_watch(3, 1, 3, seen);
    chk(seen, 1'b0, "R8 3+3 split by one agreeing sample");
    settle(2, 1'b0);
    pulse_watch(4, 0, 0, seen);
    chk(seen, 1'b1, "R8 control run of 4");
  endtask

  task automatic t_no_base();
    settle(4, 1'b0);
    @(negedge clk);
    smp_base_en = 1'b0;
    raw_in      = 1'b1;
    repeat (200) @(negedge clk);
    chk(lvl_out, 1'b0, "R9 no base enable, code 4");
    smp_base_en = 1'b1;
    repeat (40) @(negedge clk);
    chk(lvl_out, 1'b1, "R9 base enable restored");
    settle(0, 1'b0);
    @(negedge clk);
    smp_base_en = 1'b0;
    raw_in      = 1'b1;
    repeat (50) @(negedge clk);
    chk(lvl_out, 1'b0, "R9 no base enable, code 0");
    smp_base_en = 1'b1;
  endtask

  task automatic t_code_change();
    bit moved;
    settle(1, 1'b1);
    @(negedge clk);
    raw_in   = 1'b0;
    flt_code = 4'd3;
    repeat (5) @(negedge clk);
    flt_code = 4'd2;
    repeat (4) @(negedge clk);
    chk(lvl_out, 1'b1, "R10 run restarted after code change");
    @(negedge clk);
    chk(lvl_out, 1'b0, "R10 new code counts from zero");
    settle(1, 1'b1);
    moved = 0;
    for (int c = 0; c < 16; c++) begin
      flt_code = 4'(c);
      repeat (3) begin
        @(negedge clk);
        if (!lvl_out) moved = 1;
      end
    end
    chk(moved, 1'b0, "R10 code sweep keeps level");
  endtask

  initial begin
    t_reset();
    for (int c = 0; c < 16; c++) t_latency(c, 1'b1);
    t_latency(0, 1'b0);
    t_latency(3, 1'b0);
    t_latency(9, 1'b0);
    t_latency(15, 1'b0);
    t_glitch();
    t_interrupt();
    t_no_base();
    t_code_change();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule